// File: doc/BRIEF.md
# Transaction Ordering Token Arbiter

This block decides which transaction in a bridge's address-translation path may be issued next. Transactions arrive one per cycle on a single enqueue port, each tagged with a kind: outbound posted write, outbound read request, inbound configuration-write completion or inbound read completion. Writes and read requests go to their own queues; both completion kinds share a third queue. Every accepted transaction gets the next value of an 8-bit wrapping sequence stamp, and that stamp is what all ordering decisions compare.

Each cycle the block looks at the three queue heads. A head may pass only when no older outstanding transaction of a blocking class exists. Outstanding means queued or already issued but not yet retired. Issued transactions sit in a small in-flight table until a retire pulse names their slot. A mode input picks strict split-transaction ordering or relaxed conventional ordering for completions. At most one token leaves per cycle: it pops the chosen head, places it in the lowest free slot and reports kind, stamp and slot on a one-cycle pulse.

Top module: `txn_order_arb`

## Requirements
- R1: After reset no token is issued, `enq_ready` is high, all queued and in-flight transactions are discarded, and the first accepted transaction gets stamp 0 and slot 0.
- R2: Kind codes are 0 posted write, 1 read request, 2 configuration-write completion, 3 read completion. Each accepted enqueue gets a stamp one greater, modulo 256, than the previous one. The token reports that stamp and the kind.
- R3: A posted write is not issued while an older posted write is outstanding.
- R4: A read request is not issued while an older posted write or an older read request is outstanding. A younger posted write may be issued ahead of an outstanding read request.
- R5: Either completion kind is not issued while an older posted write is outstanding, in both modes.
- R6: With `split_mode` high, a configuration-write completion waits for older outstanding read completions. With `split_mode` low it does not.
- R7: With `split_mode` high, a read completion waits for older outstanding read completions and configuration-write completions. With `split_mode` low it does not.
- R8: At most one token per cycle, lasting one cycle. When several heads may pass, the one with the oldest stamp is issued first.
- R9: A token takes the lowest-numbered free slot. A retire pulse naming an occupied slot ends that transaction. A retire pulse naming a free slot has no effect.
- R10: `enq_ready` is low when the queue for the offered kind holds 4 entries, or when 8 transactions are outstanding.
- R11: `enq_ready` is low when the next stamp would be 128 or more ahead of the oldest outstanding transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_mode | input | 1 | 1: strict split-transaction completion ordering; 0: conventional |
| enq_valid | input | 1 | A transaction is offered |
| enq_kind | input | 2 | Kind of the offered transaction (codes in R2) |
| enq_ready | output | 1 | The offered transaction is accepted this cycle |
| tok_valid | output | 1 | One-cycle token pulse |
| tok_kind | output | 2 | Kind of the issued transaction |
| tok_tag | output | 3 | In-flight slot holding the issued transaction |
| tok_stamp | output | 8 | Sequence stamp of the issued transaction |
| done_valid | input | 1 | Retire pulse |
| done_tag | input | 3 | Slot being retired |

## Verification
Each ordering rule is tried with the blocker older than the head, then retired, so the bench sees a wait followed by a release. A younger write is also issued past an outstanding read, which tells an age check apart from a plain class check. The completion rules run in both modes with the same enqueue sequence, so a split-mode wait and a conventional pass come from identical traffic. Two heads released in the same cycle, in both age orders, separate oldest-first selection from a fixed queue priority. Long retire loops behind a held read drive the stamp span to its limit.

// File: rtl/txn_order_pkg.sv
package txn_order_pkg;

    typedef enum logic [1:0] {
        K_PWR  = 2'd0,
        K_RREQ = 2'd1,
        K_CFGC = 2'd2,
        K_RDC  = 2'd3
    } kind_e;

    localparam int NQ = 3;

    // queue 0: posted writes, 1: read requests, 2: both completion kinds
    function automatic logic [1:0] queue_of(kind_e k);
        case (k)
            K_PWR:   return 2'd0;
            K_RREQ:  return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/txn_order_fifo.sv
module txn_order_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic         empty,
    output logic         full,
    output logic [W-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign head  = st_q.mem[st_q.rp];

endmodule

// File: rtl/txn_order_judge.sv
module txn_order_judge
    import txn_order_pkg::*;
#(
    parameter int STAMP_W = 8,
    parameter int SLOTS   = 8
) (
    input  logic                             split_mode,
    input  logic [NQ-1:0]                    hv,
    input  logic [NQ-1:0][STAMP_W-1:0]       hs,
    input  kind_e                            ck,
    input  logic [SLOTS-1:0]                 fv,
    input  logic [SLOTS-1:0][1:0]            fk,
    input  logic [SLOTS-1:0][STAMP_W-1:0]    fs,
    output logic                             pick_v,
    output logic [NQ-1:0]                    pick_oh
);
    localparam int HALF = 1 << (STAMP_W - 1);

    // a is older than b when a - b wraps into the upper half
    function automatic logic older(input logic [STAMP_W-1:0] a, input logic [STAMP_W-1:0] b);
        return STAMP_W'(a - b) >= STAMP_W'(HALF);
    endfunction

    logic [NQ-1:0] fw, fr, fc, fd, el;
    logic          cblk;
    logic [STAMP_W-1:0] best;

    always_comb begin
        fw = '0; fr = '0; fc = '0; fd = '0;
        for (int q = 0; q < NQ; q++) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (fv[i] && older(fs[i], hs[q])) begin
                    case (fk[i])
                        K_PWR:   fw[q] = 1'b1;
                        K_RREQ:  fr[q] = 1'b1;
                        K_CFGC:  fc[q] = 1'b1;
                        default: fd[q] = 1'b1;
                    endcase
                end
            end
        end

        // R3: writes wait only for older writes
        el[0] = hv[0] && !fw[0];
        // R4: reads wait for older writes and older reads
        el[1] = hv[1] && !fw[1] && !fr[1] && !(hv[0] && older(hs[0], hs[1]));
        // R5: completions wait for older writes in every mode
        cblk = fw[2] || (hv[0] && older(hs[0], hs[2]));
        if (ck == K_CFGC) cblk = cblk || (split_mode && fd[2]);          // R6
        else              cblk = cblk || (split_mode && (fd[2] || fc[2])); // R7
        el[2] = hv[2] && !cblk;

        // R8: oldest eligible head wins
        pick_v  = 1'b0;
        pick_oh = '0;
        best    = '0;
        for (int q = 0; q < NQ; q++) begin
            if (el[q] && (!pick_v || older(hs[q], best))) begin
                pick_v  = 1'b1;
                pick_oh = NQ'(1) << q;
                best    = hs[q];
            end
        end
    end

endmodule

// File: rtl/txn_order_arb.sv
module txn_order_arb
    import txn_order_pkg::*;
#(
    parameter int STAMP_W = 8,
    parameter int SLOTS   = 8,
    parameter int QDEPTH  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        split_mode,
    input  logic                        enq_valid,
    input  logic [1:0]                  enq_kind,
    output logic                        enq_ready,
    output logic                        tok_valid,
    output logic [1:0]                  tok_kind,
    output logic [$clog2(SLOTS)-1:0]    tok_tag,
    output logic [STAMP_W-1:0]          tok_stamp,
    input  logic                        done_valid,
    input  logic [$clog2(SLOTS)-1:0]    done_tag
);
    localparam int TW   = $clog2(SLOTS);
    localparam int CW   = $clog2(SLOTS + 1);
    localparam int DW   = STAMP_W + 2;
    localparam int HALF = 1 << (STAMP_W - 1);

    typedef struct packed {
        logic [SLOTS-1:0]              fv;
        logic [SLOTS-1:0][1:0]         fk;
        logic [SLOTS-1:0][STAMP_W-1:0] fs;
        logic [STAMP_W-1:0]            stamp;
        logic [CW-1:0]                 cnt;
        logic                          tv;
        logic [1:0]                    tk;
        logic [TW-1:0]                 tt;
        logic [STAMP_W-1:0]            ts;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NQ-1:0][DW-1:0]      hd;
    logic [NQ-1:0][STAMP_W-1:0] hs;
    logic [NQ-1:0]              qe, qf, qpush, qpop, pick_oh;
    logic                       pick_v, enq_fire, done_hit, grant, free_ok;
    logic [TW-1:0]              free_idx;
    logic [STAMP_W-1:0]         age, maxage;
    logic [1:0]                 qsel;

    generate
        for (genvar g = 0; g < NQ; g++) begin : g_q
            txn_order_fifo #(.W(DW), .DEPTH(QDEPTH)) u_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (qpush[g]),
                .wdata ({enq_kind, st_q.stamp}),
                .pop   (qpop[g]),
                .empty (qe[g]),
                .full  (qf[g]),
                .head  (hd[g])
            );
            assign hs[g] = hd[g][STAMP_W-1:0];
        end
    endgenerate

    txn_order_judge #(.STAMP_W(STAMP_W), .SLOTS(SLOTS)) u_judge (
        .split_mode (split_mode),
        .hv         (~qe),
        .hs         (hs),
        .ck         (kind_e'(hd[2][DW-1:STAMP_W])),
        .fv         (st_q.fv),
        .fk         (st_q.fk),
        .fs         (st_q.fs),
        .pick_v     (pick_v),
        .pick_oh    (pick_oh)
    );

    always_comb begin
        st_d = st_q;

        // lowest free in-flight slot (R9)
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!st_q.fv[i]) begin
                free_ok  = 1'b1;
                free_idx = TW'(i);
            end
        end

        // distance from next stamp back to the oldest outstanding one (R11)
        maxage = '0;
        age    = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (st_q.fv[i]) begin
                age = st_q.stamp - st_q.fs[i];
                if (age > maxage) maxage = age;
            end
        end
        for (int q = 0; q < NQ; q++) begin
            if (!qe[q]) begin
                age = st_q.stamp - hs[q];
                if (age > maxage) maxage = age;
            end
        end

        qsel      = queue_of(kind_e'(enq_kind));
        enq_ready = (st_q.cnt < CW'(SLOTS)) && !qf[qsel] && (maxage < STAMP_W'(HALF)); // R10 R11
        enq_fire  = enq_valid && enq_ready;
        grant     = pick_v && free_ok;
        done_hit  = done_valid && st_q.fv[done_tag];

        for (int q = 0; q < NQ; q++) begin
            qpush[q] = enq_fire && (qsel == 2'(q));
            qpop[q]  = grant && pick_oh[q];
        end

        st_d.tv = grant;
        if (done_hit) st_d.fv[done_tag] = 1'b0;
        if (grant) begin
            for (int q = 0; q < NQ; q++) begin
                if (pick_oh[q]) begin
                    st_d.tk = hd[q][DW-1:STAMP_W];
                    st_d.ts = hs[q];
                end
            end
            st_d.tt = free_idx;
            st_d.fv[free_idx] = 1'b1;
            st_d.fk[free_idx] = st_d.tk;
            st_d.fs[free_idx] = st_d.ts;
        end

        if (enq_fire) st_d.stamp = st_q.stamp + 1'b1;
        st_d.cnt = st_q.cnt + CW'(enq_fire) - CW'(done_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tok_valid = st_q.tv;
    assign tok_kind  = st_q.tk;
    assign tok_tag   = st_q.tt;
    assign tok_stamp = st_q.ts;

    logic [SLOTS-1:0]   infl_v;
    logic [CW-1:0]      out_cnt;
    logic [STAMP_W-1:0] stamp_now;
    assign infl_v    = st_q.fv;
    assign out_cnt   = st_q.cnt;
    assign stamp_now = st_q.stamp;

endmodule

// File: rtl/txn_order_chk.sv
module txn_order_chk #(
    parameter int STAMP_W = 8,
    parameter int SLOTS   = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         enq_valid,
    input logic                         enq_ready,
    input logic                         tok_valid,
    input logic [$clog2(SLOTS)-1:0]     tok_tag,
    input logic                         done_valid,
    input logic [$clog2(SLOTS)-1:0]     done_tag,
    input logic [SLOTS-1:0]             infl_v,
    input logic [$clog2(SLOTS+1)-1:0]   out_cnt,
    input logic [STAMP_W-1:0]           stamp_now
);
    localparam int CW = $clog2(SLOTS + 1);

    AST_TOKEN_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |-> infl_v[tok_tag]);                                          // R9
    AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && infl_v[done_tag]) |=> !infl_v[$past(done_tag)]);          // R9
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cnt == CW'(SLOTS)) |-> !enq_ready);                                 // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= CW'(SLOTS));                                                  // R10
    AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_ready) |=> (stamp_now == $past(stamp_now) + 1'b1));   // R2
    AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(enq_valid && enq_ready) |=> $stable(stamp_now));                       // R2

endmodule

bind txn_order_arb txn_order_chk #(.STAMP_W(STAMP_W), .SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid  (enq_valid),
    .enq_ready  (enq_ready),
    .tok_valid  (tok_valid),
    .tok_tag    (tok_tag),
    .done_valid (done_valid),
    .done_tag   (done_tag),
    .infl_v     (infl_v),
    .out_cnt    (out_cnt),
    .stamp_now  (stamp_now)
);

// File: tb/sim_txn_order_arb.sv
module sim_txn_order_arb;
    localparam int KW = 0, KR = 1, KC = 2, KD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       split_mode = 1'b1;
    logic       enq_valid = 1'b0;
    logic [1:0] enq_kind = 2'd0;
    logic       enq_ready;
    logic       tok_valid;
    logic [1:0] tok_kind;
    logic [2:0] tok_tag;
    logic [7:0] tok_stamp;
    logic       done_valid = 1'b0;
    logic [2:0] done_tag = 3'd0;

    int nchk = 0, nbad = 0;
    int lk[1024], ls[1024], lt[1024];
    int nlog = 0, base = 0;

    always #10 clk = ~clk;

    txn_order_arb u0 (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode),
        .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_ready(enq_ready),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_tag(tok_tag), .tok_stamp(tok_stamp),
        .done_valid(done_valid), .done_tag(done_tag)
    );

    always @(negedge clk) begin
        if (rst_n && tok_valid) begin
            if (nlog < 1024) begin
                lk[nlog] = int'(tok_kind);
                ls[nlog] = int'(tok_stamp);
                lt[nlog] = int'(tok_tag);
            end
            nlog = nlog + 1;
        end
    end

    task automatic check(string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset(logic mode);
        @(negedge clk);
        rst_n = 1'b0; enq_valid = 1'b0; done_valid = 1'b0; split_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        base = nlog;
    endtask

    task automatic enq(int k);
        @(negedge clk);
        enq_valid = 1'b1; enq_kind = 2'(k);
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic retire(int t);
        @(negedge clk);
        done_valid = 1'b1; done_tag = 3'(t);
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int cnt();
        return nlog - base;
    endfunction

    task automatic ready_for(int k, int exp, string what);
        @(negedge clk);
        enq_kind = 2'(k);
        #1 check(what, int'(enq_ready), exp);
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        check("R1 no token after reset", int'(tok_valid), 0);
        check("R1 ready after reset", int'(enq_ready), 1);
        enq(KD); idle(3);
        check("R2 first token count", cnt(), 1);
        check("R1 first stamp", ls[base], 0);
        check("R1 first slot", lt[base], 0);
        check("R2 kind read completion", lk[base], KD);
        enq(KR); idle(3);
        check("R2 second token count", cnt(), 2);
        check("R2 stamp step", ls[base+1], 1);
        check("R2 kind read request", lk[base+1], KR);
        // reset in the middle of traffic
        enq(KW); enq(KW); idle(2);
        do_reset(1'b1);
        check("R1 ready after mid reset", int'(enq_ready), 1);
        idle(3);
        check("R1 queued work dropped", cnt(), 0);
        enq(KW); idle(3);
        check("R1 stamp restarts", ls[base], 0);
        check("R1 slot restarts", lt[base], 0);
    endtask

    task automatic t_write_order;
        do_reset(1'b1);
        enq(KW); enq(KW); idle(3);
        check("R3 younger write held", cnt(), 1);
        retire(3); idle(3);
        check("R9 retire of free slot ignored", cnt(), 1);
        retire(0); idle(3);
        check("R3 younger write released", cnt(), 2);
        check("R3 released stamp", ls[base+1], 1);
        check("R9 lowest free slot reused", lt[base+1], 0);
    endtask

    task automatic t_read_order;
        do_reset(1'b1);
        enq(KW); enq(KR); idle(3);
        check("R4 read held behind write", cnt(), 1);
        retire(0); idle(3);
        check("R4 read released", cnt(), 2);
        check("R4 read kind", lk[base+1], KR);
        enq(KR); idle(3);
        check("R4 read held behind read", cnt(), 2);
        retire(0); idle(3);
        check("R4 second read released", cnt(), 3);
        check("R4 second read stamp", ls[base+2], 2);
        enq(KW); idle(3);
        check("R4 younger write passes read", cnt(), 4);
        check("R4 passing write kind", lk[base+3], KW);
        check("R9 passing write slot", lt[base+3], 1);
    endtask

    task automatic t_cpl_behind_write;
        for (int m = 0; m < 2; m++) begin
            for (int c = KC; c <= KD; c++) begin
                do_reset(1'(m));
                enq(KW); enq(c); idle(3);
                check("R5 completion held behind write", cnt(), 1);
                retire(0); idle(3);
                check("R5 completion released", cnt(), 2);
                check("R5 completion kind", lk[base+1], c);
            end
        end
    endtask

    task automatic t_mode(logic split);
        do_reset(split);
        enq(KD); enq(KC); idle(3);
        check("R6 cfg completion vs older read completion", cnt(), split ? 1 : 2);
        enq(KD); idle(3);
        check("R7 read completion vs older completions", cnt(), split ? 1 : 3);
        if (split) begin
            retire(0); idle(3);
            check("R6 cfg completion released", cnt(), 2);
            check("R6 released kind", lk[base+1], KC);
            idle(2);
            check("R7 read completion held by cfg completion", cnt(), 2);
            retire(0); idle(3);
            check("R7 read completion released", cnt(), 3);
            check("R7 released stamp", ls[base+2], 2);
            do_reset(1'b1);
            enq(KD); enq(KD); idle(3);
            check("R7 read completion held by read completion", cnt(), 1);
        end else begin
            check("R7 conventional stamp", ls[base+2], 2);
        end
    endtask

    task automatic t_oldest;
        do_reset(1'b1);
        enq(KW); enq(KC); enq(KR); idle(3);
        check("R8 both held", cnt(), 1);
        retire(0); idle(4);
        check("R8 both released", cnt(), 3);
        check("R8 older completion first", lk[base+1], KC);
        check("R8 younger read second", lk[base+2], KR);
        check("R9 first free slot", lt[base+1], 0);
        check("R9 next free slot", lt[base+2], 1);
        do_reset(1'b1);
        enq(KW); enq(KR); enq(KC); idle(3);
        retire(0); idle(4);
        check("R8 older read first", lk[base+1], KR);
        check("R8 younger completion second", lk[base+2], KC);
    endtask

    task automatic t_capacity;
        do_reset(1'b1);
        for (int i = 0; i < 5; i++) enq(KW);
        idle(2);
        ready_for(KW, 0, "R10 write queue full");
        ready_for(KR, 1, "R10 read queue has room");
        for (int i = 0; i < 3; i++) enq(KR);
        idle(2);
        ready_for(KC, 0, "R10 eight outstanding");
        retire(0); idle(3);
        ready_for(KC, 1, "R10 room after retire");
    endtask

    task automatic t_span;
        do_reset(1'b1);
        enq(KR);
        for (int i = 1; i <= 127; i++) begin
            enq(KW);
            retire(1);
        end
        idle(2);
        check("R11 all writes issued", cnt(), 128);
        check("R11 last write stamp", ls[base+127], 127);
        ready_for(KW, 0, "R11 span limit reached");
        retire(0);
        ready_for(KW, 1, "R11 span freed by retire");
    endtask

    initial begin
        t_reset();
        t_write_order();
        t_read_order();
        t_cpl_behind_write();
        t_mode(1'b1);
        t_mode(1'b0);
        t_oldest();
        t_capacity();
        t_span();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule